// File: doc/BRIEF.md
# I2C Master Bit Engine

A command-driven bit sequencer for a single-master I2C bus. It produces bus conditions and byte transfers on open-drain SCL and SDA by pulling a line low or letting it go; it never drives a line high. Four commands are accepted: START condition, STOP condition, write one byte and sample the receiver's acknowledge, and read one byte and return ACK or NACK. A controller above it builds transactions such as an address byte followed by data out of these commands.

Every phase of every sequence is a multiple of a quarter-bit period Q, given in clock cycles on a port and latched when a command is accepted. Whenever the engine lets SCL go, it polls the synchronized SCL line until it is actually high. A target can therefore stretch the clock. If SCL stays low for longer than a fixed cycle budget, the engine abandons the command. A START retries while SDA is seen held low, and a STOP confirms that SDA really rose. A command that fails ends at once with a single-cycle done and success low.

Top module: `i2c_bit_engine`

## Requirements
- R1: After reset both line pull-down enables are 0 (lines released), and done_o, success_o, ack_o and rdata_o are all 0.
- R2: A START command (cmd_i = 2'b00) makes SDA fall while SCL is high, then pulls SCL low. It completes with success_o = 1 and with both pull-down enables left at 1.
- R3: During START, SDA is released and checked once per Q. Each check that finds SDA low counts as a failed attempt. After START_RETRIES+1 failed attempts the command ends with success_o = 0. If SDA comes free before the attempts run out, the START completes normally.
- R4: A WRITE command (cmd_i = 2'b10) shifts wdata_i out MSB first. SDA changes only while the engine holds SCL low, and each bit is valid across an SCL high phase. On the ninth pulse the engine releases SDA and samples it: low gives ack_o = 1 and success_o = 1, high gives ack_o = 0 and success_o = 0.
- R5: A READ command (cmd_i = 2'b11) samples SDA MSB first, once per SCL high phase, and presents the byte on rdata_o at done. On the ninth pulse the engine pulls SDA low (ACK) when more_i = 1 and leaves it released (NACK) when more_i = 0.
- R6: A STOP command (cmd_i = 2'b01) pulls SCL then SDA low, releases SCL, waits for it to go high, then releases SDA, so SDA rises while SCL is high. It succeeds with both enables 0 if SDA reads high at one of STOP_CHECKS checks spaced Q apart, and fails otherwise.
- R7: Each time SCL is released, the engine does not continue until the synchronized SCL reads high. A target holding SCL low for less than the timeout only delays the transfer, and the transfer still completes correctly.
- R8: If SCL is still low once the polling (one check per Q after an initial Q) has used more than STRETCH_TIMEOUT cycles, the command ends immediately with done_o = 1 and success_o = 0.
- R9: A quarter_i value of 0 is treated as 1, so commands complete with the same timing as quarter_i = 1.
- R10: done_o is a single-cycle pulse, one per accepted command, and is never asserted in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe, taken only while idle |
| cmd_i | input | 2 | 00 START, 01 STOP, 10 WRITE, 11 READ |
| wdata_i | input | 8 | Byte to send on WRITE |
| more_i | input | 1 | READ: 1 returns ACK, 0 returns NACK |
| quarter_i | input | QW | Quarter-bit period in clock cycles (0 acts as 1) |
| scl_i | input | 1 | SCL line level (asynchronous) |
| sda_i | input | 1 | SDA line level (asynchronous) |
| scl_low_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_low_o | output | 1 | 1 pulls SDA low, 0 releases it |
| done_o | output | 1 | One-cycle pulse at command completion |
| success_o | output | 1 | Outcome of the last command |
| ack_o | output | 1 | Acknowledge seen on the last WRITE |
| rdata_o | output | 8 | Byte from the last READ |

## Verification
The bench builds the engine with QW = 8, STRETCH_TIMEOUT = 64, START_RETRIES = 3 and STOP_CHECKS = 3, and drives Q = 4 for most commands. With these values a clock-stretch timeout happens within about eighty cycles, so the bench can check its latency against a tight window. A 30-cycle stretch stays inside the budget. A stuck SDA exhausts the START attempts within a few dozen cycles. An open-drain target model on the bench side acknowledges, supplies read bytes and records the master's ACK/NACK, and the same model holds either line low on demand. Q = 0 and Q = 1 are run back to back and their START latencies compared.

// File: rtl/i2c_bit_pkg.sv
package i2c_bit_pkg;

  typedef enum logic [1:0] {
    CMD_START = 2'b00,
    CMD_STOP  = 2'b01,
    CMD_WRITE = 2'b10,
    CMD_READ  = 2'b11
  } cmd_e;

  typedef enum logic [3:0] {
    OP_DLY1, OP_DLY2, OP_SCL_LO, OP_SCL_REL, OP_SDA_LO, OP_SDA_REL,
    OP_SDA_BIT, OP_SDA_MORE, OP_WAIT_HI, OP_LOOP, OP_START_CHK,
    OP_STOP_CHK, OP_SAMPLE_BIT, OP_SAMPLE_ACK, OP_FINISH
  } op_e;

  localparam int PC_W = 5;
  localparam logic [PC_W-1:0] PC_START_RETRY = 5'd3;
  localparam logic [PC_W-1:0] PC_STOP_RETRY  = 5'd7;

endpackage

// File: rtl/i2c_bit_sync.sv
module i2c_bit_sync #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta, stab;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta <= 1'b1;
        stab <= 1'b1;
      end else begin
        meta <= d_i[i];
        stab <= meta;
      end
    end
    assign q_o[i] = stab;
  end
endmodule

// File: rtl/i2c_bit_timer.sv
module i2c_bit_timer #(
  parameter int W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         idle_o
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt <= '0;
    else if (load_i)      cnt <= val_i;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign idle_o = (cnt == '0);
endmodule

// File: rtl/i2c_bit_prog.sv
module i2c_bit_prog
  import i2c_bit_pkg::*;
(
  input  cmd_e            cmd_i,
  input  logic [PC_W-1:0] pc_i,
  output op_e             op_o
);
  always_comb begin
    op_o = OP_FINISH;
    unique case (cmd_i)
      CMD_START: case (pc_i)
        5'd0:  op_o = OP_SCL_REL;
        5'd1:  op_o = OP_DLY1;
        5'd2:  op_o = OP_SDA_REL;
        5'd3:  op_o = OP_DLY1;
        5'd4:  op_o = OP_START_CHK;
        5'd5:  op_o = OP_DLY1;
        5'd6:  op_o = OP_SCL_REL;
        5'd7:  op_o = OP_WAIT_HI;
        5'd8:  op_o = OP_SDA_LO;
        5'd9:  op_o = OP_DLY1;
        5'd10: op_o = OP_SCL_LO;
        5'd11: op_o = OP_DLY1;
        default: op_o = OP_FINISH;
      endcase
      CMD_STOP: case (pc_i)
        5'd0:  op_o = OP_SCL_LO;
        5'd1:  op_o = OP_DLY1;
        5'd2:  op_o = OP_SDA_LO;
        5'd3:  op_o = OP_DLY1;
        5'd4:  op_o = OP_SCL_REL;
        5'd5:  op_o = OP_WAIT_HI;
        5'd6:  op_o = OP_SDA_REL;
        5'd7:  op_o = OP_DLY1;
        5'd8:  op_o = OP_STOP_CHK;
        default: op_o = OP_FINISH;
      endcase
      CMD_WRITE: case (pc_i)
        5'd0:  op_o = OP_DLY1;
        5'd1:  op_o = OP_SDA_BIT;
        5'd2:  op_o = OP_DLY1;
        5'd3:  op_o = OP_SCL_REL;
        5'd4:  op_o = OP_WAIT_HI;
        5'd5:  op_o = OP_SCL_LO;
        5'd6:  op_o = OP_LOOP;
        5'd7:  op_o = OP_DLY1;
        5'd8:  op_o = OP_SDA_REL;
        5'd9:  op_o = OP_DLY1;
        5'd10: op_o = OP_SCL_REL;
        5'd11: op_o = OP_WAIT_HI;
        5'd12: op_o = OP_SAMPLE_ACK;
        5'd13: op_o = OP_DLY2;
        5'd14: op_o = OP_SCL_LO;
        5'd15: op_o = OP_DLY2;
        default: op_o = OP_FINISH;
      endcase
      CMD_READ: case (pc_i)
        5'd0:  op_o = OP_SCL_REL;
        5'd1:  op_o = OP_WAIT_HI;
        5'd2:  op_o = OP_SAMPLE_BIT;
        5'd3:  op_o = OP_SCL_LO;
        5'd4:  op_o = OP_DLY2;
        5'd5:  op_o = OP_LOOP;
        5'd6:  op_o = OP_DLY1;
        5'd7:  op_o = OP_SDA_MORE;
        5'd8:  op_o = OP_DLY1;
        5'd9:  op_o = OP_SCL_REL;
        5'd10: op_o = OP_WAIT_HI;
        5'd11: op_o = OP_SCL_LO;
        5'd12: op_o = OP_DLY1;
        5'd13: op_o = OP_SDA_REL;
        5'd14: op_o = OP_DLY1;
        default: op_o = OP_FINISH;
      endcase
      default: op_o = OP_FINISH;
    endcase
  end
endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
  import i2c_bit_pkg::*;
#(
  parameter int QW              = 12,
  parameter int STRETCH_TIMEOUT = 64,
  parameter int START_RETRIES   = 3,
  parameter int STOP_CHECKS     = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  logic [1:0]    cmd_i,
  input  logic [7:0]    wdata_i,
  input  logic          more_i,
  input  logic [QW-1:0] quarter_i,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_low_o,
  output logic          sda_low_o,
  output logic          done_o,
  output logic          success_o,
  output logic          ack_o,
  output logic [7:0]    rdata_o
);
  localparam int TW   = QW + 1;
  localparam int AW   = $clog2(STRETCH_TIMEOUT + (1 << QW) + 1) + 1;
  localparam int RMAX = (START_RETRIES > STOP_CHECKS) ? START_RETRIES : STOP_CHECKS;
  localparam int RW   = $clog2(RMAX + 1) + 1;
  localparam logic [AW-1:0] TMO       = AW'(STRETCH_TIMEOUT);
  localparam logic [RW-1:0] START_LIM = RW'(START_RETRIES);
  localparam logic [RW-1:0] STOP_LIM  = RW'(STOP_CHECKS - 1);

  logic            busy;
  cmd_e            cmd_q;
  logic [PC_W-1:0] pc;
  logic [QW-1:0]   q_q;
  logic [2:0]      bit_idx;
  logic [7:0]      shreg;
  logic            more_q, ack_q, wh_armed;
  logic [AW-1:0]   acc, acc_nxt;
  logic [RW-1:0]   rty;
  logic            scl_s, sda_s;
  logic            tmr_idle, tmr_load, step;
  logic [TW-1:0]   tmr_val, q1, q2;
  logic            fail_now, fin_now;
  op_e             op;

  i2c_bit_sync #(.W(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   ({scl_s, sda_s})
  );

  i2c_bit_timer #(.W(TW)) u_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(tmr_load),
    .val_i (tmr_val),
    .idle_o(tmr_idle)
  );

  i2c_bit_prog u_prog (
    .cmd_i(cmd_q),
    .pc_i (pc),
    .op_o (op)
  );

  assign q1      = (q_q == '0) ? TW'(1) : TW'(q_q);
  assign q2      = q1 << 1;
  assign acc_nxt = acc + AW'(q1);
  assign step    = busy && tmr_idle;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    fail_now = 1'b0;
    fin_now  = 1'b0;
    if (step) begin
      case (op)
        OP_DLY1: begin tmr_load = 1'b1; tmr_val = q1 - 1'b1; end
        OP_DLY2: begin tmr_load = 1'b1; tmr_val = q2 - 1'b1; end
        OP_WAIT_HI: begin
          if (!wh_armed) begin
            tmr_load = 1'b1;
            tmr_val  = q1 - 1'b1;
          end else if (!scl_s) begin
            if (acc_nxt > TMO) fail_now = 1'b1;
            else begin
              tmr_load = 1'b1;
              tmr_val  = q1 - 1'b1;
            end
          end
        end
        OP_START_CHK: fail_now = !sda_s && (rty == START_LIM);
        OP_STOP_CHK: begin
          fin_now  = sda_s;
          fail_now = !sda_s && (rty == STOP_LIM);
        end
        OP_FINISH: fin_now = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy      <= 1'b0;
      cmd_q     <= CMD_START;
      pc        <= '0;
      q_q       <= '0;
      bit_idx   <= '0;
      shreg     <= '0;
      more_q    <= 1'b0;
      ack_q     <= 1'b0;
      wh_armed  <= 1'b0;
      acc       <= '0;
      rty       <= '0;
      scl_low_o <= 1'b0;
      sda_low_o <= 1'b0;
      done_o    <= 1'b0;
      success_o <= 1'b0;
      ack_o     <= 1'b0;
      rdata_o   <= '0;
    end else begin
      done_o <= 1'b0;
      if (!busy) begin
        if (cmd_valid_i) begin
          busy     <= 1'b1;
          cmd_q    <= cmd_e'(cmd_i);
          pc       <= '0;
          q_q      <= quarter_i;
          shreg    <= wdata_i;
          more_q   <= more_i;
          bit_idx  <= 3'd7;
          rty      <= '0;
          ack_q    <= 1'b0;
          wh_armed <= 1'b0;
        end
      end else if (fail_now) begin
        busy      <= 1'b0;
        wh_armed  <= 1'b0;
        done_o    <= 1'b1;
        success_o <= 1'b0;
        if (cmd_q == CMD_WRITE) ack_o <= 1'b0;
      end else if (fin_now) begin
        busy      <= 1'b0;
        done_o    <= 1'b1;
        success_o <= (cmd_q == CMD_WRITE) ? ack_q : 1'b1;
        if (cmd_q == CMD_WRITE) ack_o <= ack_q;
        if (cmd_q == CMD_READ) rdata_o <= shreg;
      end else if (step) begin
        case (op)
          OP_DLY1, OP_DLY2: pc <= pc + 1'b1;
          OP_SCL_LO:   begin scl_low_o <= 1'b1; pc <= pc + 1'b1; end
          OP_SCL_REL:  begin scl_low_o <= 1'b0; pc <= pc + 1'b1; end
          OP_SDA_LO:   begin sda_low_o <= 1'b1; pc <= pc + 1'b1; end
          OP_SDA_REL:  begin sda_low_o <= 1'b0; pc <= pc + 1'b1; end
          OP_SDA_BIT: begin
            sda_low_o <= !shreg[7];
            shreg     <= {shreg[6:0], 1'b0};
            pc        <= pc + 1'b1;
          end
          OP_SDA_MORE: begin sda_low_o <= more_q; pc <= pc + 1'b1; end
          OP_WAIT_HI: begin
            if (!wh_armed) begin
              wh_armed <= 1'b1;
              acc      <= '0;
            end else if (scl_s) begin
              wh_armed <= 1'b0;
              pc       <= pc + 1'b1;
            end else begin
              acc <= acc_nxt;
            end
          end
          OP_LOOP: begin
            if (bit_idx != 3'd0) begin
              bit_idx <= bit_idx - 1'b1;
              pc      <= '0;
            end else begin
              pc <= pc + 1'b1;
            end
          end
          OP_START_CHK: begin
            if (sda_s) pc <= pc + 1'b1;
            else begin
              rty <= rty + 1'b1;
              pc  <= PC_START_RETRY;
            end
          end
          OP_STOP_CHK: begin
            rty <= rty + 1'b1;
            pc  <= PC_STOP_RETRY;
          end
          OP_SAMPLE_BIT: begin shreg <= {shreg[6:0], sda_s}; pc <= pc + 1'b1; end
          OP_SAMPLE_ACK: begin ack_q <= !sda_s; pc <= pc + 1'b1; end
          default: ;
        endcase
      end
    end
  end

endmodule

module i2c_bit_engine_chk
  import i2c_bit_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic busy,
  input cmd_e cmd_q,
  input logic done_o,
  input logic success_o,
  input logic ack_o,
  input logic scl_low_o,
  input logic sda_low_o
);
  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R10
  done_after_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy));

  // R2
  start_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && success_o && cmd_q == CMD_START) |-> (scl_low_o && sda_low_o));

  // R6
  stop_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && success_o && cmd_q == CMD_STOP) |-> (!scl_low_o && !sda_low_o));

  // R4
  write_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cmd_q == CMD_WRITE) |-> (success_o == ack_o));

  // R4
  sda_under_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(busy) && busy && cmd_q[1] && (sda_low_o != $past(sda_low_o)))
      |-> $past(scl_low_o));
endmodule

bind i2c_bit_engine i2c_bit_engine_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .busy     (busy),
  .cmd_q    (cmd_q),
  .done_o   (done_o),
  .success_o(success_o),
  .ack_o    (ack_o),
  .scl_low_o(scl_low_o),
  .sda_low_o(sda_low_o)
);

// File: tb/i2c_bit_engine_test.sv
module i2c_bit_engine_test;
  localparam int QW = 8;
  localparam int TMO = 64;
  localparam int QB = 4;
  localparam logic [1:0] C_START = 2'b00, C_STOP = 2'b01, C_WRITE = 2'b10, C_READ = 2'b11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, more = 1'b0;
  logic [1:0] cmd = '0;
  logic [7:0] wdata = '0;
  logic [QW-1:0] quarter = QW'(QB);
  logic scl_low_o, sda_low_o, done_o, success_o, ack_o;
  logic [7:0] rdata_o;

  // bus and target model
  logic stretch = 1'b0, sda_stuck = 1'b0, tx_mode = 1'b0, ack_en = 1'b1;
  logic [7:0] tx_byte = '0, rx_sh = '0, rx_byte = '0;
  logic mack_seen = 1'b0, start_seen = 1'b0, stop_seen = 1'b0;
  logic slv_low;
  logic p_scl = 1'b1, p_sda = 1'b1;
  int bcnt = -1;
  wire scl_line = !(scl_low_o || stretch);
  wire sda_line = !(sda_low_o || slv_low || sda_stuck);

  int nchk = 0, nerr = 0, lat = 0;

  typedef struct {
    logic es; logic ca; logic ea; logic cr; logic [7:0] er; string tag;
  } exp_t;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  i2c_bit_engine #(.QW(QW), .STRETCH_TIMEOUT(TMO), .START_RETRIES(3), .STOP_CHECKS(3)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_i(cmd), .wdata_i(wdata),
    .more_i(more), .quarter_i(quarter), .scl_i(scl_line), .sda_i(sda_line),
    .scl_low_o(scl_low_o), .sda_low_o(sda_low_o), .done_o(done_o), .success_o(success_o),
    .ack_o(ack_o), .rdata_o(rdata_o)
  );

  always_comb begin
    slv_low = 1'b0;
    if (bcnt >= 0 && bcnt < 8 && tx_mode) slv_low = !tx_byte[3'(7 - bcnt)];
    else if (bcnt == 8 && !tx_mode && ack_en) slv_low = 1'b1;
  end

  always @(scl_line or sda_line) begin
    if (sda_line !== p_sda && scl_line && p_scl) begin
      bcnt = -1;
      if (!sda_line) start_seen = 1'b1;
      else stop_seen = 1'b1;
    end else if (scl_line && !p_scl) begin
      if (bcnt >= 0 && bcnt < 8) rx_sh = {rx_sh[6:0], sda_line};
      else if (bcnt == 8) mack_seen = !sda_line;
    end else if (!scl_line && p_scl) begin
      if (bcnt == 8) begin
        rx_byte = rx_sh;
        bcnt = 0;
      end else bcnt = bcnt + 1;
    end
    p_scl = scl_line;
    p_sda = sda_line;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, expv);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && done_o) begin
        if (exp_q.size() == 0) check(0, "R10", "unexpected done", 1, 0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          check(success_o == e.es, e.tag, "success", int'(success_o), int'(e.es));
          if (e.ca) check(ack_o == e.ea, e.tag, "ack", int'(ack_o), int'(e.ea));
          if (e.cr) check(rdata_o == e.er, e.tag, "rdata", int'(rdata_o), int'(e.er));
        end
      end
    end
  end

  task automatic issue(input logic [1:0] c, input logic [7:0] wd, input logic mr, input int q,
                       input logic es, input logic ca, input logic ea,
                       input logic cr, input logic [7:0] er, input string tag);
    exp_t e;
    e.es = es; e.ca = ca; e.ea = ea; e.cr = cr; e.er = er; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    cmd = c; wdata = wd; more = mr; quarter = QW'(q); cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    lat = 1;
    while (!done_o) begin
      @(negedge clk);
      lat++;
    end
    @(negedge clk);
    check(done_o == 1'b0, "R10", "done width", int'(done_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(!scl_low_o && !sda_low_o, "R1", "line enables", {scl_low_o, sda_low_o}, 0);
    check(!done_o && !success_o && !ack_o, "R1", "status", {done_o, success_o, ack_o}, 0);
    check(rdata_o == 8'h00, "R1", "rdata", rdata_o, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 START, R4 write ack / nack, R6 STOP
    start_seen = 1'b0;
    issue(C_START, 8'h00, 0, QB, 1, 0, 0, 0, 8'h00, "R2");
    check(start_seen, "R2", "start condition", int'(start_seen), 1);
    check(scl_low_o && sda_low_o, "R2", "lines held", {scl_low_o, sda_low_o}, 3);
    issue(C_WRITE, 8'hA6, 0, QB, 1, 1, 1, 0, 8'h00, "R4");
    check(rx_byte == 8'hA6, "R4", "target byte", rx_byte, 8'hA6);
    ack_en = 1'b0;
    issue(C_WRITE, 8'h5B, 0, QB, 0, 1, 0, 0, 8'h00, "R4");
    check(rx_byte == 8'h5B, "R4", "nack target byte", rx_byte, 8'h5B);
    ack_en = 1'b1;
    stop_seen = 1'b0;
    issue(C_STOP, 8'h00, 0, QB, 1, 0, 0, 0, 8'h00, "R6");
    check(stop_seen, "R6", "stop condition", int'(stop_seen), 1);
    check(!scl_low_o && !sda_low_o, "R6", "lines free", {scl_low_o, sda_low_o}, 0);

    // R5 reads with ACK then NACK
    issue(C_START, 8'h00, 0, QB, 1, 0, 0, 0, 8'h00, "R2");
    issue(C_WRITE, 8'h91, 0, QB, 1, 1, 1, 0, 8'h00, "R4");
    tx_byte = 8'hA5; tx_mode = 1'b1;
    issue(C_READ, 8'h00, 1, QB, 1, 0, 0, 1, 8'hA5, "R5");
    check(mack_seen == 1'b1, "R5", "master ack", int'(mack_seen), 1);
    tx_byte = 8'h3C;
    issue(C_READ, 8'h00, 0, QB, 1, 0, 0, 1, 8'h3C, "R5");
    check(mack_seen == 1'b0, "R5", "master nack", int'(mack_seen), 0);
    tx_mode = 1'b0;
    issue(C_STOP, 8'h00, 0, QB, 1, 0, 0, 0, 8'h00, "R6");

    // R7 clock stretch inside budget
    issue(C_START, 8'h00, 0, QB, 1, 0, 0, 0, 8'h00, "R2");
    stretch = 1'b1;
    fork begin repeat (30) @(posedge clk); stretch = 1'b0; end join_none
    issue(C_WRITE, 8'h47, 0, QB, 1, 1, 1, 0, 8'h00, "R7");
    check(rx_byte == 8'h47, "R7", "stretched byte", rx_byte, 8'h47);
    check(lat > 30, "R7", "waited for release", lat, 31);
    issue(C_STOP, 8'h00, 0, QB, 1, 0, 0, 0, 8'h00, "R6");

    // R8 timeout
    issue(C_START, 8'h00, 0, QB, 1, 0, 0, 0, 8'h00, "R2");
    stretch = 1'b1;
    issue(C_WRITE, 8'h33, 0, QB, 0, 1, 0, 0, 8'h00, "R8");
    check(lat > TMO && lat < TMO + 6 * QB + 20, "R8", "timeout latency", lat, TMO);
    stretch = 1'b0;
    issue(C_STOP, 8'h00, 0, QB, 1, 0, 0, 0, 8'h00, "R6");

    // R3 START retries
    sda_stuck = 1'b1;
    issue(C_START, 8'h00, 0, QB, 0, 0, 0, 0, 8'h00, "R3");
    sda_stuck = 1'b0;
    repeat (4) @(negedge clk);
    sda_stuck = 1'b1;
    fork begin repeat (8) @(posedge clk); sda_stuck = 1'b0; end join_none
    issue(C_START, 8'h00, 0, QB, 1, 0, 0, 0, 8'h00, "R3");
    check(scl_low_o && sda_low_o, "R3", "start after release", {scl_low_o, sda_low_o}, 3);

    // R6 STOP with SDA held low
    sda_stuck = 1'b1;
    issue(C_STOP, 8'h00, 0, QB, 0, 0, 0, 0, 8'h00, "R6");
    sda_stuck = 1'b0;
    issue(C_STOP, 8'h00, 0, QB, 1, 0, 0, 0, 8'h00, "R6");

    // R9 quarter of zero behaves as one
    begin
      int lat1;
      issue(C_START, 8'h00, 0, 1, 1, 0, 0, 0, 8'h00, "R9");
      lat1 = lat;
      issue(C_STOP, 8'h00, 0, 1, 1, 0, 0, 0, 8'h00, "R9");
      issue(C_START, 8'h00, 0, 0, 1, 0, 0, 0, 8'h00, "R9");
      check(lat == lat1, "R9", "start latency", lat, lat1);
      issue(C_WRITE, 8'h5A, 0, 0, 1, 1, 1, 0, 8'h00, "R9");
      check(rx_byte == 8'h5A, "R9", "byte at q0", rx_byte, 8'h5A);
      issue(C_STOP, 8'h00, 0, 0, 1, 0, 0, 0, 8'h00, "R9");
    end

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R10", "pending results", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule